// File: doc/BRIEF.md
# I2C Double-Buffered Data Register

This block sits between a host register interface and an I2C bit-level engine and carries the data of one frame in each direction. On the receive side the engine hands over the bits of a finished frame with a one-cycle strobe. The block either places them straight into a holding buffer that the host reads, or, if the host has not yet collected the previous byte, keeps them back in a shift register. It then moves them into the holding buffer when the host reads. On the transmit side the host writes a data register, and the block presents the bits the engine has to send.

A frame carries 1 to 8 data bits, not counting the acknowledge bit. A bit-order control decides how a short frame lines up within the 8-bit host byte. A module enable gates all host access. Bus timing, START/STOP detection, arbitration and address matching are handled elsewhere.

Top module: `i2c_dbuf_datareg`

## Requirements
- R1: In receive mode (`rx_mode_i`=1), with the block enabled and the full flag clear, a frame-done strobe loads the aligned frame into the holding buffer and sets the full flag. Both are visible on the first clock edge after the strobe.
- R2: A frame that completes while the full flag is 1 is held back and the holding buffer keeps its contents. The next host read moves it into the holding buffer, and the full flag stays 1 across that read.
- R3: A host read with no held-back frame, and with no frame completing in the same cycle, clears the full flag.
- R4: In transmit mode (`rx_mode_i`=0) nothing is ever moved into the holding buffer. Frame-done strobes and reads leave its contents unchanged.
- R5: Receive alignment. Let n be the frame length. The engine delivers the n received bits in `frame_bits_i[n-1:0]`, with the first bit received at position n-1, and the bits above n-1 are ignored. With `bit_order_i`=0 the byte reads as those n bits at the LSB end. With `bit_order_i`=1 they are shifted up to the MSB end. Every other bit reads as 0.
- R6: Transmit alignment. `tx_bits_o[n-1:0]` carries the n bits to send, with the first bit to send at position n-1. With `bit_order_i`=0 they are taken from data register bits [7:8-n]. With `bit_order_i`=1 they are taken from bits [n-1:0]. Bits n and above of `tx_bits_o` are 0.
- R7: `frame_len_i` is a 3-bit field. Value 0 selects 8 bits, and values 1 to 7 select that many bits.
- R8: While `enable_i`=0, host reads return 0, and host reads, host writes and frame-done strobes have no effect on any state.
- R9: When a host read and a frame-done strobe fall in the same cycle, the read returns the holding buffer as it was before that cycle. The frame is then handled after the read's effect on the flag.
- R10: After reset the full flag is 0 and no frame is held back. Data contents are not defined until first written.
- R11: A frame that completes while a frame is already held back replaces the held-back frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable; gates all host access and frame intake |
| rx_mode_i | input | 1 | 1 = receive mode, 0 = transmit mode |
| bit_order_i | input | 1 | Short-frame alignment select |
| frame_len_i | input | 3 | Data bits per frame, 0 means 8 |
| frame_done_i | input | 1 | One-cycle strobe: a frame has been shifted in |
| frame_bits_i | input | 8 | Bits of the completed frame, LSB-justified |
| host_rd_i | input | 1 | Host read strobe of the data register |
| host_wr_i | input | 1 | Host write strobe of the data register |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (holding buffer, 0 when disabled) |
| full_o | output | 1 | Holding buffer holds an unread byte |
| tx_bits_o | output | 8 | Aligned bits for the engine to transmit |

## Verification
The hardest state to reach is a held-back frame that meets a host read in the same cycle as yet another frame-done strobe. Here the buffer must take the older frame, the shift register must take the newest one, and the flag must stay set. The bench gets there by strobing two frames in without reading, and then issuing a read together with a third strobe. It also walks every frame length and both bit orders over several data patterns, in both directions, and compares each result with a value computed from the length arithmetic.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;

    parameter int DW = 8;
    parameter int LW = $clog2(DW);

    typedef logic [DW-1:0] byte_t;
    typedef logic [LW-1:0] len_t;
    typedef logic [LW:0]   cnt_t;

    // Number of data bits selected by the length field; zero means a full byte.
    function automatic cnt_t frame_bits(input len_t len);
        return (len == '0) ? cnt_t'(DW) : {1'b0, len};
    endfunction

    // Ones over the low frame_bits(len) positions.
    function automatic byte_t frame_mask(input len_t len);
        byte_t ones;
        ones = '1;
        return ones >> (DW - int'(frame_bits(len)));
    endfunction

endpackage

// File: rtl/i2c_dbuf_rxalign.sv
module i2c_dbuf_rxalign
    import i2c_dbuf_pkg::*;
(
    input  byte_t raw_i,
    input  len_t  len_i,
    input  logic  order_i,
    output byte_t aligned_o
);

    byte_t masked;
    int    pad;

    always_comb begin
        masked = raw_i & frame_mask(len_i);
        pad    = DW - int'(frame_bits(len_i));
        if (order_i) begin
            aligned_o = masked << pad;
        end else begin
            aligned_o = masked;
        end
    end

endmodule

// File: rtl/i2c_dbuf_rxctl.sv
module i2c_dbuf_rxctl
    import i2c_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable_i,
    input  logic  rx_mode_i,
    input  logic  frame_done_i,
    input  byte_t aligned_i,
    input  logic  host_rd_i,
    output byte_t hold_o,
    output logic  full_o
);

    typedef struct packed {
        byte_t shift;
        byte_t hold;
        logic  full;
        logic  pend;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable_i) begin
            // Read effect first: the host sees st_q.hold this cycle.
            if (host_rd_i) begin
                if (st_q.pend && rx_mode_i) begin
                    st_d.hold = st_q.shift;
                    st_d.full = 1'b1;
                    st_d.pend = 1'b0;
                end else if (!st_q.pend) begin
                    st_d.full = 1'b0;
                end
            end
            if (frame_done_i && rx_mode_i) begin
                if (!st_d.full) begin
                    st_d.hold = aligned_i;
                    st_d.full = 1'b1;
                end else begin
                    st_d.shift = aligned_i;
                    st_d.pend  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
    assign full_o = st_q.full;

    p_direct_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && rx_mode_i && frame_done_i && !st_q.full && !host_rd_i
        |=> st_q.full && st_q.hold == $past(aligned_i));

    p_defer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && rx_mode_i && frame_done_i && st_q.full && !host_rd_i
        |=> st_q.pend && st_q.full && $stable(st_q.hold));

    p_deferred_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && rx_mode_i && host_rd_i && st_q.pend
        |=> st_q.full && st_q.hold == $past(st_q.shift));

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && host_rd_i && !st_q.pend && !frame_done_i
        |=> !st_q.full);

    p_tx_no_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && !rx_mode_i |=> $stable(st_q.hold));

    p_disabled_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> $stable(st_q));

    p_pend_implies_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.full);

endmodule

// File: rtl/i2c_dbuf_txpath.sv
module i2c_dbuf_txpath
    import i2c_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable_i,
    input  logic  host_wr_i,
    input  byte_t host_wdata_i,
    input  len_t  len_i,
    input  logic  order_i,
    output byte_t tx_bits_o
);

    byte_t txreg_d, txreg_q;
    int    pad;

    always_comb begin
        txreg_d = txreg_q;
        if (enable_i && host_wr_i) begin
            txreg_d = host_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txreg_q <= '0;
        end else begin
            txreg_q <= txreg_d;
        end
    end

    always_comb begin
        pad = DW - int'(frame_bits(len_i));
        if (order_i) begin
            tx_bits_o = txreg_q & frame_mask(len_i);
        end else begin
            tx_bits_o = txreg_q >> pad;
        end
    end

    p_write_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_i && host_wr_i) |=> $stable(txreg_q));

    p_tx_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bits_o & ~frame_mask(len_i)) == '0);

endmodule

// File: rtl/i2c_dbuf_datareg.sv
module i2c_dbuf_datareg
    import i2c_dbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          rx_mode_i,
    input  logic          bit_order_i,
    input  logic [LW-1:0] frame_len_i,
    input  logic          frame_done_i,
    input  logic [DW-1:0] frame_bits_i,
    input  logic          host_rd_i,
    input  logic          host_wr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    output logic          full_o,
    output logic [DW-1:0] tx_bits_o
);

    byte_t aligned;
    byte_t hold;

    i2c_dbuf_rxalign u_rxalign (
        .raw_i     (frame_bits_i),
        .len_i     (frame_len_i),
        .order_i   (bit_order_i),
        .aligned_o (aligned)
    );

    i2c_dbuf_rxctl u_rxctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .rx_mode_i    (rx_mode_i),
        .frame_done_i (frame_done_i),
        .aligned_i    (aligned),
        .host_rd_i    (host_rd_i),
        .hold_o       (hold),
        .full_o       (full_o)
    );

    i2c_dbuf_txpath u_txpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .len_i        (frame_len_i),
        .order_i      (bit_order_i),
        .tx_bits_o    (tx_bits_o)
    );

    assign host_rdata_o = enable_i ? hold : '0;

    p_disabled_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> host_rdata_o == '0);

    p_rx_outside_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && rx_mode_i && frame_done_i && !full_o && !host_rd_i
        |=> $countones(host_rdata_o) <= int'(frame_bits($past(frame_len_i))));

endmodule

// File: tb/i2c_dbuf_datareg_test.sv
`timescale 1ns/1ps
module i2c_dbuf_datareg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       rx_mode_i = 1'b1;
    logic       bit_order_i = 1'b0;
    logic [2:0] frame_len_i = 3'd0;
    logic       frame_done_i = 1'b0;
    logic [7:0] frame_bits_i = 8'h00;
    logic       host_rd_i = 1'b0;
    logic       host_wr_i = 1'b0;
    logic [7:0] host_wdata_i = 8'h00;
    logic [7:0] host_rdata_o;
    logic       full_o;
    logic [7:0] tx_bits_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_dbuf_datareg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .rx_mode_i    (rx_mode_i),
        .bit_order_i  (bit_order_i),
        .frame_len_i  (frame_len_i),
        .frame_done_i (frame_done_i),
        .frame_bits_i (frame_bits_i),
        .host_rd_i    (host_rd_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .full_o       (full_o),
        .tx_bits_o    (tx_bits_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic int nbits(input logic [2:0] len);
        return (len == 3'd0) ? 8 : int'(len);
    endfunction

    function automatic logic [7:0] exp_rx(input logic [7:0] raw, input logic [2:0] len, input logic ord);
        int n;
        logic [7:0] v;
        n = nbits(len);
        v = raw % (8'd1 << n);
        if (n == 8) v = raw;
        return ord ? (v << (8 - n)) : v;
    endfunction

    function automatic logic [7:0] exp_tx(input logic [7:0] d, input logic [2:0] len, input logic ord);
        int n;
        n = nbits(len);
        if (ord) return (n == 8) ? d : (d % (8'd1 << n));
        return d >> (8 - n);
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic frame(input logic [7:0] raw);
        frame_done_i = 1'b1;
        frame_bits_i = raw;
        @(negedge clk);
        frame_done_i = 1'b0;
        frame_bits_i = 8'h00;
    endtask

    task automatic rd(output logic [7:0] seen);
        host_rd_i = 1'b1;
        #1 seen = host_rdata_o;
        @(negedge clk);
        host_rd_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        host_wr_i = 1'b1;
        host_wdata_i = d;
        @(negedge clk);
        host_wr_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 100000 cycles expected fewer");
        report();
        $finish;
    end

    initial begin
        logic [7:0] seen;
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        enable_i = 1'b1;
        @(negedge clk);
        chk("R10 full after reset", {7'd0, full_o}, 8'h00);

        // Receive sweep: both orders, all lengths, several patterns (R1 R3 R5 R7)
        rx_mode_i = 1'b1;
        for (int o = 0; o < 2; o++) begin
            for (int l = 0; l < 8; l++) begin
                for (int k = 0; k < 4; k++) begin
                    bit_order_i = o[0];
                    frame_len_i = l[2:0];
                    pat = 8'hA5 ^ 8'(k * 8'h3B) ^ 8'(l << 4);
                    frame(pat);
                    chk("R1 full set", {7'd0, full_o}, 8'h01);
                    chk($sformatf("R5/R7 rx len=%0d ord=%0d", l, o), host_rdata_o,
                        exp_rx(pat, l[2:0], o[0]));
                    rd(seen);
                    chk("R5 read data", seen, exp_rx(pat, l[2:0], o[0]));
                    chk("R3 full cleared", {7'd0, full_o}, 8'h00);
                end
            end
        end

        // Transmit sweep (R6 R7)
        rx_mode_i = 1'b0;
        for (int o = 0; o < 2; o++) begin
            for (int l = 0; l < 8; l++) begin
                for (int k = 0; k < 4; k++) begin
                    bit_order_i = o[0];
                    frame_len_i = l[2:0];
                    pat = 8'h5C ^ 8'(k * 8'h6D) ^ 8'(l);
                    wr(pat);
                    chk($sformatf("R6/R7 tx len=%0d ord=%0d", l, o), tx_bits_o,
                        exp_tx(pat, l[2:0], o[0]));
                end
            end
        end

        // Deferred path (R2)
        rx_mode_i = 1'b1;
        bit_order_i = 1'b0;
        frame_len_i = 3'd0;
        frame(8'h11);
        frame(8'h22);
        chk("R2 buffer kept", host_rdata_o, 8'h11);
        chk("R2 full kept", {7'd0, full_o}, 8'h01);
        rd(seen);
        chk("R2 read old", seen, 8'h11);
        chk("R2 moved in", host_rdata_o, 8'h22);
        chk("R2 full stays", {7'd0, full_o}, 8'h01);
        rd(seen);
        chk("R3 full cleared after deferred", {7'd0, full_o}, 8'h00);

        // Overrun of held-back frame (R11)
        frame(8'h31);
        frame(8'h32);
        frame(8'h33);
        rd(seen);
        chk("R11 newest held frame", host_rdata_o, 8'h33);
        rd(seen);

        // Transmit mode: no transfer (R4)
        rx_mode_i = 1'b0;
        frame(8'h44);
        chk("R4 no load in tx", {7'd0, full_o}, 8'h00);
        chk("R4 buffer unchanged", host_rdata_o, 8'h33);
        rx_mode_i = 1'b1;
        frame(8'h55);
        frame(8'h66);
        rx_mode_i = 1'b0;
        rd(seen);
        chk("R4 no move on tx read", host_rdata_o, 8'h55);
        rx_mode_i = 1'b1;
        rd(seen);
        chk("R2 move after back to rx", host_rdata_o, 8'h66);
        rd(seen);

        // Disabled (R8)
        frame(8'h77);
        enable_i = 1'b0;
        #1 chk("R8 read returns zero", host_rdata_o, 8'h00);
        rd(seen);
        chk("R8 read zero", seen, 8'h00);
        chk("R8 read no clear", {7'd0, full_o}, 8'h01);
        frame(8'h88);
        wr(8'hF0);
        enable_i = 1'b1;
        #1 chk("R8 frame ignored", host_rdata_o, 8'h77);
        rd(seen);
        chk("R8 no pending frame", {7'd0, full_o}, 8'h00);
        frame_len_i = 3'd0;
        bit_order_i = 1'b1;
        chk("R8 write ignored", tx_bits_o, 8'h5C ^ 8'(3 * 8'h6D) ^ 8'd7);

        // Same-cycle read and frame (R9)
        bit_order_i = 1'b0;
        frame(8'h9A);
        host_rd_i = 1'b1;
        frame_done_i = 1'b1;
        frame_bits_i = 8'h9B;
        #1 seen = host_rdata_o;
        @(negedge clk);
        host_rd_i = 1'b0;
        frame_done_i = 1'b0;
        chk("R9 read old contents", seen, 8'h9A);
        chk("R9 new frame loaded", host_rdata_o, 8'h9B);
        chk("R9 full set", {7'd0, full_o}, 8'h01);
        rd(seen);

        // Same-cycle read and frame with held-back frame (R9 R2)
        frame(8'hC1);
        frame(8'hC2);
        host_rd_i = 1'b1;
        frame_done_i = 1'b1;
        frame_bits_i = 8'hC3;
        #1 seen = host_rdata_o;
        @(negedge clk);
        host_rd_i = 1'b0;
        frame_done_i = 1'b0;
        chk("R9 pend read old", seen, 8'hC1);
        chk("R9 pend moved", host_rdata_o, 8'hC2);
        rd(seen);
        chk("R9 newest next", host_rdata_o, 8'hC3);
        chk("R9 full after", {7'd0, full_o}, 8'h01);
        rd(seen);
        chk("R3 final clear", {7'd0, full_o}, 8'h00);

        report();
        $finish;
    end

endmodule